// File: doc/BRIEF.md
# Adjustable Rail Startup Sequencer

This block brings up an external adjustable regulator once, right after the device has been configured. It keeps the regulator switched off, waits a timed gap, puts the voltage-select code on its two select lines, waits a second gap, and then switches the regulator on. Once the regulator is on, the block waits for a settle interval before raising a ready flag. The application logic downstream keeps its own reset asserted until that flag is high. The default settle interval is long enough to cover the regulator's soft start of roughly 10.6 ms.

The block has no reset pin. Its registers start from their power-on values, and its step counter advances only on clock edges where the clock-lock input is high. After the ready flag rises, the counter stops and the outputs keep their final values until the device is configured again. Every gap is a parameter counted in clock cycles. The defaults give about 200 ms per step at 100 MHz, and a testbench can shrink them.

Top module: `rail_startup_seq`

## Requirements
- R1: From power-on, and before any locked clock edge, the regulator enable is 0, the select code is binary 00 and ready is 0.
- R2: The step counter advances only on clock edges where lock_i is 1. While lock_i is 0 before the sequence completes, no output changes, and the count neither restarts nor is lost.
- R3: The select output changes from 00 to VSEL_CODE after STEP_CYCLES locked edges. The default VSEL_CODE is binary 10, which selects the 2.5 V setting. Enable is still 0 when this happens.
- R4: Enable rises after a further STEP_CYCLES locked edges. When enable rises, the select output already holds VSEL_CODE.
- R5: Ready rises exactly SETTLE_CYCLES locked edges after the edge on which enable rose.
- R6: Once enable is 1, it stays 1 whatever lock_i does.
- R7: Once ready is 1, all three outputs hold their values permanently, whatever lock_i does.
- R8: After the select step, the select output never changes again.
- R9: Whenever ready is 1, enable is 1 and the select output equals VSEL_CODE.
- R10: The counter never reaches the limit of the current step, and the sequence moves forward by at most one step on any edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock, usually derived from the PLL |
| lock_i | input | 1 | Clock-stable flag; the counter advances only while this is 1 |
| reg_en_o | output | 1 | Regulator enable, registered |
| vsel_o | output | 2 | Regulator voltage-select code, registered |
| ready_o | output | 1 | Rail settled; release the application reset when this is 1 |

## Verification
On every cycle, the assertions check the following:
- enable and ready never fall once set (stickiness);
- the select code never moves after the select step;
- enable rises only with the code already in place, and ready appears only together with both;
- the counter stays below its step limit and holds while lock is low;
- the sequence moves forward by at most one step per edge.

The exact edges on which select, enable and ready change, counted in locked cycles only, can be shown only by the bench scenarios. The same holds for the effect of lock dropouts in each phase and for the output state after completion.

// File: rtl/railseq_pkg.sv
package railseq_pkg;
  // Sequence phases, in the only order the block may visit them.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // regulator off, code 00
    PH_SELECT = 2'd1,  // regulator off, code applied
    PH_RAMP   = 2'd2,  // regulator on, waiting for settle
    PH_DONE   = 2'd3   // frozen, ready high
  } phase_e;
endpackage

// File: rtl/railseq_timer.sv
module railseq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             armed_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wrap_o
);
  // Power-on value is the only starting condition.
  logic [CNT_W-1:0] cnt_q = '0;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign wrap_o = run_i && (cnt_q == limit_i - CNT_W'(1));
  assign cnt_en = run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (wrap_o) cnt_d = '0;
      else        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    cnt_q <= cnt_d;
  end

  // R2: no advance without lock
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!armed_i)
    !run_i |=> $stable(cnt_q));
  // R10: counter stays below the active limit
  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!armed_i)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/railseq_phase.sv
module railseq_phase
  import railseq_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned STEP_CYCLES   = 20,
  parameter int unsigned SETTLE_CYCLES = 10
) (
  input  logic             clk_i,
  input  logic             armed_i,
  input  logic             lock_i,
  input  logic             wrap_i,
  output logic             run_o,
  output logic [CNT_W-1:0] limit_o,
  output phase_e           phase_next_o
);
  phase_e phase_q = PH_IDLE;
  phase_e phase_d;

  // Once the sequence is done, the counter is frozen for good.
  assign run_o = lock_i && (phase_q != PH_DONE);

  always_comb begin
    limit_o = CNT_W'(STEP_CYCLES);
    if (phase_q == PH_RAMP) limit_o = CNT_W'(SETTLE_CYCLES);
  end

  always_comb begin
    phase_d = phase_q;
    if (wrap_i) phase_d = phase_e'(phase_q + 2'd1);
  end

  assign phase_next_o = phase_d;

  always_ff @(posedge clk_i) begin
    phase_q <= phase_d;
  end

  // R10: one step at most per edge, forward only
  assert_phase_order_R10: assert property (@(posedge clk_i) disable iff (!armed_i)
    (phase_q != $past(phase_q)) |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));
  // R7: the done phase is terminal
  assert_phase_final_R7: assert property (@(posedge clk_i) disable iff (!armed_i)
    (phase_q == PH_DONE) |=> (phase_q == PH_DONE));
endmodule

// File: rtl/railseq_drive.sv
module railseq_drive
  import railseq_pkg::*;
#(
  parameter int unsigned VSEL_W    = 2,
  parameter logic [VSEL_W-1:0] VSEL_CODE = 2'b10
) (
  input  logic              clk_i,
  input  logic              armed_i,
  input  phase_e            phase_next_i,
  output logic              en_o,
  output logic [VSEL_W-1:0] vsel_o,
  output logic              ready_o
);
  logic              en_q    = 1'b0;
  logic [VSEL_W-1:0] vsel_q  = '0;
  logic              rdy_q   = 1'b0;
  logic              en_d;
  logic [VSEL_W-1:0] vsel_d;
  logic              rdy_d;

  // Decode the next phase so each output comes straight from a flop.
  always_comb begin
    en_d   = (phase_next_i == PH_RAMP) || (phase_next_i == PH_DONE);
    vsel_d = (phase_next_i == PH_IDLE) ? '0 : VSEL_CODE;
    rdy_d  = (phase_next_i == PH_DONE);
  end

  always_ff @(posedge clk_i) begin
    en_q   <= en_d;
    vsel_q <= vsel_d;
    rdy_q  <= rdy_d;
  end

  assign en_o    = en_q;
  assign vsel_o  = vsel_q;
  assign ready_o = rdy_q;

  // R6: enable is sticky
  assert_en_sticky_R6: assert property (@(posedge clk_i) disable iff (!armed_i)
    en_q |=> en_q);
  // R8: code frozen after the select step
  assert_vsel_frozen_R8: assert property (@(posedge clk_i) disable iff (!armed_i)
    (vsel_q != '0) |=> $stable(vsel_q));
  // R4: enable only rises onto a programmed code
  assert_en_after_code_R4: assert property (@(posedge clk_i) disable iff (!armed_i)
    $rose(en_q) |-> (vsel_q == VSEL_CODE) && $stable(vsel_q));
  // R9: ready implies rail programmed and on
  assert_ready_consistent_R9: assert property (@(posedge clk_i) disable iff (!armed_i)
    rdy_q |-> en_q && (vsel_q == VSEL_CODE));
  // R7: all outputs hold after ready
  assert_ready_hold_R7: assert property (@(posedge clk_i) disable iff (!armed_i)
    rdy_q |=> rdy_q && $stable(en_q) && $stable(vsel_q));
endmodule

// File: rtl/rail_startup_seq.sv
module rail_startup_seq
  import railseq_pkg::*;
#(
  parameter int unsigned STEP_CYCLES   = 20_000_000,
  parameter int unsigned SETTLE_CYCLES = 1_200_000,
  parameter int unsigned VSEL_W        = 2,
  parameter logic [VSEL_W-1:0] VSEL_CODE = 2'b10
) (
  input  logic              clk_i,
  input  logic              lock_i,
  output logic              reg_en_o,
  output logic [VSEL_W-1:0] vsel_o,
  output logic              ready_o
);
  localparam int unsigned MAX_CYC = (STEP_CYCLES > SETTLE_CYCLES) ? STEP_CYCLES : SETTLE_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  // Marks that at least one edge has passed; used to gate the checks.
  logic armed_q = 1'b0;
  always_ff @(posedge clk_i) begin
    armed_q <= 1'b1;
  end

  logic             run;
  logic             wrap;
  logic [CNT_W-1:0] limit;
  phase_e           phase_next;

  railseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .armed_i (armed_q),
    .run_i   (run),
    .limit_i (limit),
    .wrap_o  (wrap)
  );

  railseq_phase #(
    .CNT_W         (CNT_W),
    .STEP_CYCLES   (STEP_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_phase (
    .clk_i        (clk_i),
    .armed_i      (armed_q),
    .lock_i       (lock_i),
    .wrap_i       (wrap),
    .run_o        (run),
    .limit_o      (limit),
    .phase_next_o (phase_next)
  );

  railseq_drive #(
    .VSEL_W    (VSEL_W),
    .VSEL_CODE (VSEL_CODE)
  ) u_drive (
    .clk_i        (clk_i),
    .armed_i      (armed_q),
    .phase_next_i (phase_next),
    .en_o         (reg_en_o),
    .vsel_o       (vsel_o),
    .ready_o      (ready_o)
  );

  // R1: power-on outputs are all quiet
  initial begin
    assert_por_quiet_R1: assert (reg_en_o == 1'b0 && ready_o == 1'b0);
  end
endmodule

// File: tb/sim_rail_startup_seq.sv
module sim_rail_startup_seq;
  localparam int unsigned STEP   = 20;
  localparam int unsigned SETTLE = 7;
  localparam logic [1:0]  CODE   = 2'b10;

  logic       clk  = 1'b0;
  logic       lock = 1'b0;
  logic       en;
  logic [1:0] vsel;
  logic       rdy;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         ended  = 1'b0;

  always #5ns clk = ~clk;

  rail_startup_seq #(
    .STEP_CYCLES   (STEP),
    .SETTLE_CYCLES (SETTLE),
    .VSEL_CODE     (CODE)
  ) u0 (
    .clk_i    (clk),
    .lock_i   (lock),
    .reg_en_o (en),
    .vsel_o   (vsel),
    .ready_o  (rdy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int e_en, input int e_sel, input int e_rdy);
    chk(req, "reg_en", int'(en), e_en);
    chk(req, "vsel", int'(vsel), e_sel);
    chk(req, "ready", int'(rdy), e_rdy);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1, R2: quiet outputs and no progress while unlocked
  task automatic t_unlocked_start();
    wait_n(5);
    outs("R1", 0, 0, 0);
    wait_n(50);
    outs("R2", 0, 0, 0);
  endtask

  // R3: select code appears after one step of locked edges
  task automatic t_select_step();
    lock = 1'b1;
    wait_n(STEP - 1);
    outs("R3", 0, 0, 0);
    wait_n(1);
    outs("R3", 0, int'(CODE), 0);
  endtask

  // R2, R4, R8: pause mid-step, then enable at the counted edge
  task automatic t_pause_then_enable();
    wait_n(5);
    lock = 1'b0;
    wait_n(40);
    outs("R2", 0, int'(CODE), 0);
    lock = 1'b1;
    wait_n(STEP - 5 - 1);
    outs("R4", 0, int'(CODE), 0);
    wait_n(1);
    outs("R4", 1, int'(CODE), 0);
  endtask

  // R5, R6: enable survives lock loss, ready after the settle count
  task automatic t_settle();
    wait_n(3);
    lock = 1'b0;
    wait_n(25);
    outs("R6", 1, int'(CODE), 0);
    lock = 1'b1;
    wait_n(SETTLE - 3 - 1);
    outs("R5", 1, int'(CODE), 0);
    wait_n(1);
    outs("R5", 1, int'(CODE), 1);
    outs("R9", 1, int'(CODE), 1);
  endtask

  // R7, R8: outputs frozen under lock toggling
  task automatic t_frozen();
    for (int i = 0; i < 120; i++) begin
      if (i % 7 == 0) lock = ~lock;
      wait_n(1);
      if (i % 10 == 0) outs("R7", 1, int'(CODE), 1);
    end
    chk("R8", "vsel final", int'(vsel), int'(CODE));
  endtask

  initial begin
    t_unlocked_start();
    t_select_step();
    t_pause_then_enable();
    t_settle();
    t_frozen();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule